// File: doc/BRIEF.md
# Resistance-Thermometer Converter Register Interface

This block is the digital side of a resistance-to-digital temperature converter, seen by a host as an SPI target. Each transaction opens with a command byte: its top bit picks a write or a read, and its three low bits give the starting register address. Data bytes follow. The register file has four live locations: a configuration byte, the high and low bytes of a 16-bit conversion result, and a sticky fault status byte.

A host starts a measurement by writing the configuration with the bias bit and the one-shot bit both set. An internal timer then models the conversion time. That time depends on the line-rejection bit: a 62.5 ms conversion or a 52 ms conversion, each scaled by a cycles-per-millisecond parameter. When the timer runs out, the 15-bit sample on the `adc_value` test input is latched into the result. The lowest result bit takes a flag that shows whether any fault was pending at that moment. Fault events come in on `fault_in` and are accumulated until the host clears them through the configuration byte.

Top module: `rtd_spi_regs`

## Requirements
- R1: The command byte decides the direction. Bit 7 = 1 writes the following bytes and bit 7 = 0 reads them. Bits 2:0 give the starting address and bits 6:3 are ignored.
- R2: Address 0 holds the configuration, 1 the result high byte, 2 the result low byte and 7 the fault status. All other addresses read as 0x00. Writes to any address other than 0 have no effect.
- R3: The configuration bits are: 7 bias on, 5 one-shot request, 4 three-wire connection, 1 fault clear, 0 filter select (1 = 50 Hz, 0 = 60 Hz). Bits 5 and 1 always read back as 0. Every other written bit reads back as written.
- R4: After each data byte, read or write, the address moves up by one and wraps modulo 8. A two-byte read from address 1 returns the high byte and then the low byte.
- R5: After a conversion, the high byte is `adc_value[14:8]`… specifically `adc_value[14:7]`, and the low byte is `{adc_value[6:0], flag}`.
- R6: A conversion lasts CYC_PER_MS*62.5 clocks when bit 0 = 1 and CYC_PER_MS*52 clocks when bit 0 = 0. The result registers do not change before the conversion ends.
- R7: A configuration write that sets bit 5 but leaves bit 7 at 0 starts no conversion, and the result keeps its value.
- R8: Each `fault_in` bit that is high for one clock sets the matching status bit. A set bit stays set until it is cleared.
- R9: A configuration write with bit 1 = 1 sets all status bits to zero. In that cycle the clear takes priority over any `fault_in` bit.
- R10: The low result bit is 1 exactly when any fault status bit is set at the moment the conversion completes.
- R11: The block works in SPI mode 1 and in mode 3. The idle clock level is captured when chip select falls. MOSI is sampled on each edge that returns the clock to idle. MISO changes on each edge that leaves idle, MSB first.
- R12: Chip select high ends the transaction and resets the bit counter. A partial byte is discarded with no effect.
- R13: After reset, the configuration, the result and the fault status are all 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all SPI pins are oversampled on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | SPI serial clock |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | SPI data into the block |
| miso | output | 1 | SPI data out of the block |
| adc_value | input | 15 | Test sample latched into the result when a conversion completes |
| fault_in | input | 8 | Fault event inputs, accumulated into the status register |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is a fault event and a fault clear. The bench holds a fault input high across a configuration write that has the clear bit set. Afterwards it expects that status bit still to read as set, because it is set again after the clear. The checker judges that the clear alone wins in its own cycle.

The second pair is the end of a conversion and a fault being pending. The bench raises faults before a one-shot request and then checks the flag in the low result byte. Conversion length is judged by reading the high byte at a fixed delay between the two durations: the 60 Hz setting must already show the new sample and the 50 Hz setting must not yet show it.

// File: rtl/rtd_spi_regs.sv
module rtd_spi_regs #(
  parameter int CYC_PER_MS = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sclk,
  input  logic        cs_n,
  input  logic        mosi,
  output logic        miso,
  input  logic [14:0] adc_value,
  input  logic [7:0]  fault_in
);
  localparam int CONV_50 = CYC_PER_MS * 125 / 2;
  localparam int CONV_60 = CYC_PER_MS * 52;
  localparam int CW      = $clog2(CONV_50 + 1);

  logic [2:0] sclk_r, cs_r, mosi_r;
  logic       idle_q;
  logic [2:0] bit_q;
  logic       first_q, wr_q;
  logic [2:0] addr_q;
  logic [6:0] rx_q;
  logic [7:0] tx_q;
  logic [7:0] cfg_q, fault_q;
  logic [15:0] res_q;
  logic [CW-1:0] cnt_q;

  wire       active    = !cs_r[1];
  wire       cs_fall   = cs_r[2] && !cs_r[1];
  wire       sclk_edge = sclk_r[1] ^ sclk_r[2];
  wire       lead      = active && sclk_edge && (sclk_r[2] == idle_q);
  wire       trail     = active && sclk_edge && (sclk_r[1] == idle_q);
  wire [7:0] byte_in   = {rx_q, mosi_r[1]};
  wire       byte_done = trail && (bit_q == 3'd7);
  wire       cfg_we    = byte_done && !first_q && wr_q && (addr_q == 3'd0);
  wire       rd_load   = byte_done && (first_q ? !byte_in[7] : !wr_q);
  wire [2:0] rd_addr   = first_q ? byte_in[2:0] : addr_q;
  wire       start     = cfg_we && byte_in[5] && byte_in[7];
  wire       clr       = cfg_we && byte_in[1];

  function automatic logic [7:0] rdata(input logic [2:0] a);
    case (a)
      3'd0:    rdata = cfg_q;
      3'd1:    rdata = res_q[15:8];
      3'd2:    rdata = res_q[7:0];
      3'd7:    rdata = fault_q;
      default: rdata = 8'h00;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_r <= '0;
      cs_r   <= 3'b111;
      mosi_r <= '0;
      idle_q <= 1'b0;
    end else begin
      sclk_r <= {sclk_r[1:0], sclk};
      cs_r   <= {cs_r[1:0], cs_n};
      mosi_r <= {mosi_r[1:0], mosi};
      if (cs_fall) idle_q <= sclk_r[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q   <= '0;
      first_q <= 1'b1;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      miso    <= 1'b0;
    end else if (!active) begin
      bit_q   <= '0;
      first_q <= 1'b1;
      tx_q    <= '0;
      miso    <= 1'b0;
    end else begin
      if (trail) begin
        rx_q  <= byte_in[6:0];
        bit_q <= bit_q + 3'd1;
      end
      if (byte_done) begin
        first_q <= 1'b0;
        if (first_q) wr_q <= byte_in[7];
        addr_q <= rd_addr + ((first_q && byte_in[7]) ? 3'd0 : 3'd1);
      end
      if (rd_load) tx_q <= rdata(rd_addr);
      else if (lead) begin
        miso <= tx_q[7];
        tx_q <= {tx_q[6:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      fault_q <= '0;
      res_q   <= '0;
      cnt_q   <= '0;
    end else begin
      if (cfg_we) cfg_q <= byte_in & 8'hDD;
      fault_q <= clr ? 8'h00 : (fault_q | fault_in);
      if (start) cnt_q <= byte_in[0] ? CW'(CONV_50) : CW'(CONV_60);
      else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      if (!start && cnt_q == CW'(1)) res_q <= {adc_value, |fault_q};
    end
  end
endmodule

// File: rtl/rtd_spi_regs_chk.sv
module rtd_spi_regs_chk #(
  parameter int CW = 11,
  parameter int CONV_50 = 1250,
  parameter int CONV_60 = 1040
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [7:0]    wdata,
  input logic [7:0]    fault_q,
  input logic [15:0]   res_q,
  input logic [CW-1:0] cnt_q,
  input logic          active,
  input logic [2:0]    bit_q
);
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && wdata[1]) |=> (fault_q == 8'h00)); // R9
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && wdata[1]) |=> ((fault_q & $past(fault_q)) == $past(fault_q))); // R8
  AST_NO_BIAS_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && wdata[5] && !wdata[7] && cnt_q == '0) |=> (cnt_q == '0)); // R7
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != CW'(1)) |=> $stable(res_q)); // R6
  AST_CONV_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && wdata[5] && wdata[7]) |=>
      (cnt_q == ($past(wdata[0]) ? CW'(CONV_50) : CW'(CONV_60)))); // R6
  AST_CS_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (bit_q == 3'd0)); // R12
endmodule

bind rtd_spi_regs rtd_spi_regs_chk #(.CW(CW), .CONV_50(CONV_50), .CONV_60(CONV_60)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .wdata(byte_in), .fault_q(fault_q),
  .res_q(res_q), .cnt_q(cnt_q), .active(active), .bit_q(bit_q)
);

// File: tb/rtd_spi_regs_test.sv
module rtd_spi_regs_test;
  logic clk = 0, rst_n = 0, sclk = 0, cs_n = 1, mosi = 0;
  logic [14:0] adc_value = '0;
  logic [7:0]  fault_in = '0;
  wire miso;
  int vectors = 0, fails = 0;
  bit done = 0;
  logic [7:0] exp_fault = 0, exp_cfg = 0;
  logic [15:0] exp_res = 0;

  rtd_spi_regs #(.CYC_PER_MS(20)) uut (.*);

  always #10 clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // nbits shifted from txw[31] down; received bits land in rxw LSB-first growth
  task automatic xfer(input bit cpol, input int nbits, input logic [31:0] txw,
                      output logic [31:0] rxw);
    rxw = '0;
    sclk = cpol; tick(8);
    cs_n = 0; tick(8);
    for (int i = 0; i < nbits; i++) begin
      sclk = ~cpol; mosi = txw[31 - i]; tick(8);
      rxw = {rxw[30:0], miso};
      sclk = cpol; tick(8);
    end
    cs_n = 1; tick(8);
  endtask

  task automatic wr(input bit cpol, input logic [2:0] a, input logic [7:0] d);
    logic [31:0] r;
    xfer(cpol, 16, {5'b10000, a, d, 16'h0}, r);
  endtask

  task automatic rd3(input bit cpol, input logic [7:0] cmd, output logic [23:0] d);
    logic [31:0] r;
    xfer(cpol, 32, {cmd, 24'h0}, r);
    d = r[23:0];
  endtask

  function automatic logic [7:0] cfg_view(input logic [7:0] v);
    return v & 8'hDD;
  endfunction

  function automatic logic [15:0] res_of(input logic [14:0] a, input logic [7:0] f);
    return {a, |f};
  endfunction

  task automatic pulse_fault(input logic [7:0] v);
    fault_in = v; tick(1); fault_in = 0;
    exp_fault |= v;
  endtask

  task automatic convert(input bit cpol, input bit f50, input logic [14:0] a);
    adc_value = a;
    wr(cpol, 3'd0, 8'hA0 | {7'd0, f50});
    exp_cfg = 8'h80 | {7'd0, f50};
    tick(1400);
    exp_res = res_of(a, exp_fault);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [23:0] d;
    logic [31:0] r;
    logic [7:0] v;
    logic [14:0] a;
    void'($urandom(32'h5eed));
    tick(4); rst_n = 1; tick(4);

    // R13 reset state; R2 unused address reads zero
    rd3(0, 8'h00, d);
    check("R13 cfg", d[23:16], 8'h00);
    check("R13 res_hi", d[15:8], 8'h00);
    check("R13 res_lo", d[7:0], 8'h00);
    rd3(0, 8'h07, d);
    check("R13 fault", d[23:16], 8'h00);
    check("R2 addr0 after wrap", d[15:8], 8'h00);

    // R3 R1 random config writes, both SPI modes (R11)
    for (int i = 0; i < 20; i++) begin
      v = 8'($urandom()) & 8'hDD;
      wr(i[0], 3'd0, v);
      exp_cfg = cfg_view(v);
      rd3(~i[0], 8'h00, d);
      check("R3 cfg readback", d[23:16], exp_cfg);
      check("R11 mode switch", d[23:16], exp_cfg);
    end
    wr(0, 3'd0, 8'hA2 & 8'hDF | 8'h22);
    exp_cfg = 8'h80; exp_fault = 0;
    tick(1400);
    rd3(0, 8'h00, d);
    check("R3 self-clear bits", d[23:16], exp_cfg);

    // R8 sticky faults, R10 flag, R5 layout, R6 both filters, random samples
    for (int i = 0; i < 12; i++) begin
      if (i % 3 == 1) pulse_fault(8'($urandom()) | 8'h04);
      if (i % 3 == 2) begin wr(0, 3'd0, 8'h82); exp_fault = 0; end
      a = 15'($urandom());
      convert(i[1], i[0], a);
      rd3(i[1], 8'h01, d);
      check("R5 res_hi", d[23:16], exp_res[15:8]);
      check("R10 res_lo flag", d[15:8], exp_res[7:0]);
      check("R4 wrap to addr3", d[7:0], 8'h00);
      rd3(0, 8'h07, d);
      check("R8 fault status", d[23:16], exp_fault);
    end

    // R9 clear while fault held: re-set afterwards
    fault_in = 8'h04;
    wr(0, 3'd0, 8'h82);
    fault_in = 0; exp_fault = 8'h04;
    rd3(0, 8'h07, d);
    check("R9 clear vs held fault", d[23:16], 8'h04);
    wr(0, 3'd0, 8'h82); exp_fault = 0;
    rd3(0, 8'h07, d);
    check("R9 clear", d[23:16], 8'h00);

    // R7 one-shot without bias ignored
    adc_value = ~exp_res[15:1];
    wr(1, 3'd0, 8'h20);
    tick(1400);
    rd3(1, 8'h01, d);
    check("R7 no bias hi", d[23:16], exp_res[15:8]);
    check("R7 no bias lo", d[15:8], exp_res[7:0]);
    rd3(1, 8'h00, d);
    check("R7 cfg bit5 clear", d[23:16], 8'h00);

    // R6 timing: 60 Hz done by now, 50 Hz not yet
    adc_value = 15'h1234;
    wr(0, 3'd0, 8'hA0);
    tick(1010);
    xfer(0, 16, {8'h01, 24'h0}, r);
    check("R6 60Hz done", r[7:0], 8'h24);
    tick(1400);
    exp_res = res_of(15'h1234, 0);
    adc_value = 15'h5A5A;
    wr(0, 3'd0, 8'hA1);
    tick(1010);
    xfer(0, 16, {8'h01, 24'h0}, r);
    check("R6 50Hz pending", r[7:0], exp_res[15:8]);
    tick(1400);
    rd3(0, 8'h01, d);
    check("R6 50Hz done", d[23:16], 8'hB4);

    // R2 write to result ignored; R4 write wrap 7->0; R1 bits 6:3 ignored
    wr(0, 3'd1, 8'h55);
    rd3(0, 8'h01, d);
    check("R2 result write ignored", d[23:16], 8'hB4);
    xfer(0, 24, {8'hF7, 8'h11, 8'h91, 8'h00}, r);
    rd3(0, 8'h78, d);
    check("R4 write wraps to cfg", d[23:16], 8'h91);
    check("R1 high addr bits ignored", d[15:8], 8'hB4);

    // R12 partial bytes discarded
    xfer(1, 12, {8'h80, 8'h00, 16'h0}, r);
    xfer(0, 5, {8'h80, 24'h0}, r);
    rd3(0, 8'h00, d);
    check("R12 partial discarded", d[23:16], 8'h91);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule